// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from six sources next to an 8-bit processor core and decides when one of them is taken. The six sources are two external pins, two timer overflow strobes, a periodic time-base tick and a real-time-clock tick. Each source latches a request flag. The flags, the per-source enables and a master enable sit in two 8-bit control registers that the core reads and writes through a plain register port.

A request is taken only when all of these hold in the same cycle:
- the master enable is set;
- at least one flag is pending with its enable set;
- the core reports an instruction boundary;
- the call stack is not full;
- no register write is in progress.

When a request is taken, the block pulses a single push/call strobe and presents the fixed vector address of the winning source. In the same step it clears that source's flag and the master enable. Interrupts therefore do not nest unless software sets the master enable again.

A wake output rises whenever any enabled flag is pending, whatever the state of the master enable. There is no streaming data path: every pin is a plain control or status signal, and the block never applies back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, the acknowledge strobe is low and the wake output is low.
- R2: Control register 0 (select 0) layout:
  - bit 0: master enable;
  - bits 1, 2, 3: enables for external 0, external 1 and timer 0;
  - bits 4, 5, 6: request flags for external 0, external 1 and timer 0;
  - bit 7: always reads 0.
- R3: Control register 1 (select 1) layout:
  - bits 0, 1, 2: enables for timer 1, time base and real-time clock;
  - bits 4, 5, 6: request flags for timer 1, time base and real-time clock;
  - bits 3 and 7: always read 0.
- R4: A cycle with a timer overflow, time-base tick or real-time-clock tick input high sets that source's flag, whatever the state of its enable or the master enable.
- R5: Each external pin passes through a two-flop synchroniser. Its flag is set only on the edge selected by a per-pin parameter (default: pin 0 falling, pin 1 rising). The opposite edge sets nothing.
- R6: Acknowledge conditions:
  - a request is taken only in a cycle with the master enable set, an enabled pending flag, the instruction-boundary input high, the stack-full input low and no register write;
  - the acknowledge strobe is high for exactly the one following cycle.
- R7: Vectors and priority:
  - the vectors are 0x04 (external 0), 0x08 (external 1), 0x0C (timer 0), 0x10 (timer 1), 0x14 (time base) and 0x18 (real-time clock);
  - among several enabled pending flags, the lowest vector wins.
- R8: Taking a request clears the master enable and the flag of the serviced source. All other flags and enables are unchanged.
- R9: While the stack-full input is high, nothing is acknowledged and pending flags stay set. The request is taken at the first boundary after stack-full falls.
- R10: A register write sets each flag bit to the written value. The write wins over a hardware event for that flag in the same cycle.
- R11: The wake output is high exactly when some flag is set together with its enable, independent of the master enable.
- R12: A hardware event for the very source being acknowledged in that cycle leaves its flag set, so the new event stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select for read and write (0 or 1) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow strobes |
| tbase_tick | input | 1 | Time-base tick |
| rtc_tick | input | 1 | Real-time-clock tick |
| stack_full | input | 1 | Call stack is full |
| instr_bound | input | 1 | Core is at an instruction boundary |
| ack | output | 1 | One-cycle push/call strobe |
| vector | output | 8 | Vector address, valid while ack is high |
| wake | output | 1 | Wake request |

## Verification
The arbitration is driven with random flag and enable patterns written through the register port, combined with random stack-full levels. Each outcome is compared with a bench function that picks the lowest enabled pending source. This separates a wrong priority order or vector from a wrong gating by enables or by stack-full.

A directed drain walks all six sources out one by one, re-arming the master enable between takes. This shows that each take clears only its own flag. Further single-cycle patterns isolate the collisions:
- a register write against a tick on the same flag;
- an overflow against the acknowledge of that same source;
- an instruction boundary against a register write.

Both polarities of each external pin show that only the configured edge counts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 6;
  localparam int NEXT     = 2;
  localparam int RW       = 8;
  localparam int PER_REG  = 3;
  localparam int FLAG_LSB = 4;
  localparam int VEC_BASE = 4;
  localparam int VEC_STEP = 4;

  typedef logic [NSRC-1:0] srcvec_t;

  function automatic logic [RW-1:0] vec_addr(input int idx);
    return RW'(VEC_BASE + VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter bit FALLING = 1'b0,
  parameter int STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);
  localparam logic IDLE = FALLING;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev_q & ~sync_q[STAGES-1];
    end else begin : g_rise
      assign pulse = ~prev_q & sync_q[STAGES-1];
    end
  endgenerate

  // an edge produces a single-cycle pulse (R5)
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  output logic [RW-1:0] rd_data,
  input  srcvec_t       hw_set,
  input  srcvec_t       svc_clr,
  input  logic          master_clr,
  output logic          master,
  output srcvec_t       enable,
  output srcvec_t       flag
);
  logic    wr0, wr1;
  logic    master_q;
  srcvec_t flag_d;
  logic    unused_wbits;

  assign wr0 = wr_en & ~sel;
  assign wr1 = wr_en & sel;
  assign unused_wbits = ^{wr_data[7], wr_data[3]};

  always_ff @(posedge clk) begin
    if (!rst_n)          master_q <= 1'b0;
    else if (wr0)        master_q <= wr_data[0];
    else if (master_clr) master_q <= 1'b0;
  end
  assign master = master_q;

  // hardware set wins over service clear
  always_comb begin
    for (int i = 0; i < NSRC; i++)
      flag_d[i] = hw_set[i] ? 1'b1 : (svc_clr[i] ? 1'b0 : flag[i]);
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam bit HI     = (i >= PER_REG);
      localparam int POS    = i % PER_REG;
      localparam int EN_POS = HI ? POS : POS + 1;
      logic wr_mine;
      logic en_q, fl_q;
      assign wr_mine = HI ? wr1 : wr0;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_q <= 1'b0;
          fl_q <= 1'b0;
        end else if (wr_mine) begin
          en_q <= wr_data[EN_POS];
          fl_q <= wr_data[FLAG_LSB + POS];
        end else begin
          fl_q <= flag_d[i];
        end
      end
      assign enable[i] = en_q;
      assign flag[i]   = fl_q;

      // hardware event without a write leaves the flag set (R4)
      assert_hwset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set[i] && !wr_mine) |=> flag[i]);
    end
  endgenerate

  assign rd_data = sel ? {1'b0, flag[5:3], 1'b0, enable[5:3]}
                       : {1'b0, flag[2:0], enable[2:0], master_q};

  // write to register 0 lands in the master enable (R2)
  assert_master_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> (master == $past(wr_data[0])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  srcvec_t       req,
  output srcvec_t       grant,
  output logic          any,
  output logic [RW-1:0] vector
);
  logic [NSRC:0] higher;

  assign higher[0] = 1'b0;
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_pri
      assign higher[i+1] = higher[i] | req[i];
      assign grant[i]    = req[i] & ~higher[i];
    end
  endgenerate

  assign any = higher[NSRC];

  always_comb begin
    vector = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vector = vector | vec_addr(i);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter logic [NEXT-1:0] EXT_FALLING = 2'b01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic [NEXT-1:0] ext_pin,
  input  logic [1:0]      tmr_ovf,
  input  logic            tbase_tick,
  input  logic            rtc_tick,
  input  logic            stack_full,
  input  logic            instr_bound,
  output logic            ack,
  output logic [RW-1:0]   vector,
  output logic            wake
);
  logic [NEXT-1:0] ext_pulse;
  srcvec_t         hw_set, enable, flag, pending, grant, svc_clr;
  logic            master, any, take;
  logic [RW-1:0]   win_vec;
  logic            ack_q;
  logic [RW-1:0]   vector_q;

  generate
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
      irq_edge_sync #(.FALLING(EXT_FALLING[g]), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin[g]), .pulse(ext_pulse[g]));
    end
  endgenerate

  assign hw_set = {rtc_tick, tbase_tick, tmr_ovf, ext_pulse};

  irq_flag_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr_en(reg_wr),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .hw_set(hw_set),
    .svc_clr(svc_clr), .master_clr(take), .master(master),
    .enable(enable), .flag(flag));

  assign pending = flag & enable;

  irq_arbiter u_arb (.req(pending), .grant(grant), .any(any), .vector(win_vec));

  assign take    = master & any & instr_bound & ~stack_full & ~reg_wr;
  assign svc_clr = take ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      vector_q <= '0;
    end else begin
      ack_q <= take;
      if (take) vector_q <= win_vec;
    end
  end

  assign ack    = ack_q;
  assign vector = vector_q;
  assign wake   = |pending;

  assert_ack_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !master);
  assert_ack_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ($past(stack_full) == 1'b0));
  assert_ack_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ($past(instr_bound) && !$past(reg_wr)));
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (vector_q[1:0] == 2'b00 && vector_q >= 8'h04 && vector_q <= 8'h18));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] ext_pin = 2'b01;
  logic [1:0] tmr_ovf = 2'b00;
  logic       tbase_tick = 1'b0, rtc_tick = 1'b0;
  logic       stack_full = 1'b0, instr_bound = 1'b0;
  logic       ack, wake;
  logic [7:0] vector;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .tmr_ovf(tmr_ovf), .tbase_tick(tbase_tick), .rtc_tick(rtc_tick),
    .stack_full(stack_full), .instr_bound(instr_bound), .ack(ack),
    .vector(vector), .wake(wake));

  function automatic logic [7:0] pack0(logic m, logic [5:0] en, logic [5:0] f);
    return {1'b0, f[2:0], en[2:0], m};
  endfunction
  function automatic logic [7:0] pack1(logic [5:0] en, logic [5:0] f);
    return {1'b0, f[5:3], 1'b0, en[5:3]};
  endfunction
  function automatic int win_idx(logic [5:0] p);
    for (int i = 0; i < 6; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic s, logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic s, output logic [7:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic boundary();
    instr_bound = 1'b1;
    @(negedge clk);
    instr_bound = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 reg0", d, 8'h00);
    rd(1, d); chk("R1 reg1", d, 8'h00);
    chk("R1 ack", {7'd0, ack}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    // R2/R3 layout and reserved bits
    wr(0, 8'hFE); rd(0, d); chk("R2 reg0 bit7", d, 8'h7E);
    chk("R11 wake with master off", {7'd0, wake}, 8'h01);
    wr(1, 8'hFF); rd(1, d); chk("R3 reg1 bits3,7", d, 8'h77);
    wr(0, 8'h00); wr(1, 8'h00);
    chk("R11 wake idle", {7'd0, wake}, 8'h00);

    // R4 internal sources set flags without enables
    tmr_ovf[1] = 1'b1; @(negedge clk); tmr_ovf[1] = 1'b0;
    rd(1, d); chk("R4 timer1", d, 8'h10);
    tbase_tick = 1'b1; @(negedge clk); tbase_tick = 1'b0;
    rd(1, d); chk("R4 tbase", d, 8'h30);
    rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    rd(1, d); chk("R4 rtc", d, 8'h70);
    tmr_ovf[0] = 1'b1; @(negedge clk); tmr_ovf[0] = 1'b0;
    rd(0, d); chk("R4 timer0", d, 8'h40);
    wr(0, 8'h00); wr(1, 8'h00);

    // R5 external edges (pin0 falling, pin1 rising)
    ext_pin[0] = 1'b0; repeat (4) @(negedge clk);
    rd(0, d); chk("R5 pin0 falling", d, 8'h10);
    wr(0, 8'h00);
    ext_pin[0] = 1'b1; repeat (4) @(negedge clk);
    rd(0, d); chk("R5 pin0 rising ignored", d, 8'h00);
    ext_pin[1] = 1'b1; repeat (4) @(negedge clk);
    rd(0, d); chk("R5 pin1 rising", d, 8'h20);
    wr(0, 8'h00);
    ext_pin[1] = 1'b0; repeat (4) @(negedge clk);
    rd(0, d); chk("R5 pin1 falling ignored", d, 8'h00);

    // R7/R8 drain all six in priority order
    begin
      logic [7:0] r0 = 8'h7E;
      logic [7:0] r1 = 8'h77;
      wr(1, r1);
      for (int i = 0; i < 6; i++) begin
        wr(0, r0 | 8'h01);
        boundary();
        chk("R7 ack drain", {7'd0, ack}, 8'h01);
        chk("R7 vector drain", vector, 8'((i + 1) * 4));
        if (i < 3) r0 = r0 & ~(8'h10 << i);
        else       r1 = r1 & ~(8'h10 << (i - 3));
        rd(0, d); chk("R8 reg0 after take", d, r0);
        rd(1, d); chk("R8 reg1 after take", d, r1);
      end
      wr(0, r0 | 8'h01);
      boundary();
      chk("R6 no pending no ack", {7'd0, ack}, 8'h00);
    end

    // R9 stack full blocks
    wr(1, 8'h00); wr(0, 8'h49);
    stack_full = 1'b1; instr_bound = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 blocked", {7'd0, ack}, 8'h00);
    end
    stack_full = 1'b0;
    @(negedge clk);
    instr_bound = 1'b0;
    chk("R9 taken after release", {7'd0, ack}, 8'h01);
    chk("R9 vector", vector, 8'h0C);

    // R6 register write blocks take in that cycle
    wr(0, 8'h49);
    instr_bound = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 write cycle no ack", {7'd0, ack}, 8'h00);
    @(negedge clk);
    instr_bound = 1'b0;
    chk("R6 ack next boundary", {7'd0, ack}, 8'h01);
    @(negedge clk);
    chk("R6 one cycle pulse", {7'd0, ack}, 8'h00);
    wr(0, 8'h41);
    boundary();
    chk("R6 disabled source no ack", {7'd0, ack}, 8'h00);
    chk("R11 disabled source no wake", {7'd0, wake}, 8'h00);
    boundary();
    chk("R6 no ack without master/instr", {7'd0, ack}, 8'h00);

    // R10 write beats hardware set
    wr(0, 8'h00);
    rtc_tick = 1'b1;
    wr(1, 8'h00);
    rtc_tick = 1'b0;
    rd(1, d); chk("R10 write wins", d, 8'h00);

    // R12 event during own acknowledge keeps flag
    wr(0, 8'h49);
    instr_bound = 1'b1; tmr_ovf[0] = 1'b1;
    @(negedge clk);
    instr_bound = 1'b0; tmr_ovf[0] = 1'b0;
    chk("R12 ack", {7'd0, ack}, 8'h01);
    chk("R12 vector", vector, 8'h0C);
    rd(0, d); chk("R12 flag kept", d, 8'h48);

    // random arbitration
    for (int it = 0; it < 150; it++) begin
      logic [5:0] f, en, p;
      logic sf;
      int w;
      f  = 6'($urandom);
      en = 6'($urandom);
      sf = ($urandom % 4) == 0;
      p  = f & en;
      w  = win_idx(p);
      wr(1, pack1(en, f));
      wr(0, pack0(1'b1, en, f));
      chk("R11 random wake", {7'd0, wake}, {7'd0, |p});
      stack_full = sf;
      boundary();
      stack_full = 1'b0;
      if (w >= 0 && !sf) begin
        chk("R7 random ack", {7'd0, ack}, 8'h01);
        chk("R7 random vector", vector, 8'((w + 1) * 4));
        f[w] = 1'b0;
        rd(0, d); chk("R8 random reg0", d, pack0(1'b0, en, f));
        rd(1, d); chk("R8 random reg1", d, pack1(en, f));
      end else begin
        chk("R9 random no ack", {7'd0, ack}, 8'h00);
        rd(0, d); chk("R9 random reg0", d, pack0(1'b1, en, f));
      end
    end

    finish_run();
  end
endmodule